// File: doc/BRIEF.md
# Program counter and next-address unit

This block holds the fetch address of a 32-bit load/store processor with fixed 32-bit instruction words. Each cycle it looks at the instruction currently being executed and at the two register operands read for it. From these it chooses the next fetch address. The choices are the following word, a taken conditional branch relative to the PC, a jump into the current 256 MiB region, or a jump to an address held in a register. The jump that saves a return address also issues a write request toward the register file.

The PC register has a synchronous reset to a start address set by a parameter, and a stall input that freezes it. The link-write request is a plain single-cycle valid pulse with no ready. The register file must accept the write in the cycle it is offered, so the unit never applies back-pressure and never receives any. The link request and the misaligned-target flag are combinational outputs. They are valid in the same cycle as the instruction that causes them.

Top module: `pc_nextaddr`

## Requirements
- R1: In the clock edge where `rst` is high, `pc` loads `RESET_PC`, which defaults to 0x00400000. While `rst` is high, `link_we` and `misalign` stay 0.
- R2: Any instruction not listed in R3, R4, R6, R7 and R8 advances `pc` by 4 at the next edge. This includes register-type words (bits 31:26 = 0) whose function field (bits 5:0) is not 0x08, and unlisted opcodes such as 6.
- R3: Opcode 4 (bits 31:26) branches when `rs_val == rt_val`. The target is pc+4 plus the sign-extended 16-bit field (bits 15:0) shifted left by 2. When the operands differ, `pc` advances by 4.
- R4: Opcode 5 branches to the same target when `rs_val != rt_val`, and otherwise advances by 4.
- R5: A branch offset with bit 15 set moves the PC backwards. For example, offset 0xFFFE gives pc+4-8.
- R6: Opcode 2 loads `pc` with bits 31:28 of pc+4, followed by the 26-bit field (bits 25:0) and then two zero bits.
- R7: Opcode 3 jumps as in R6. In the same cycle it raises `link_we` for one cycle with `link_addr` = 31 and `link_data` = pc+4. No other instruction raises `link_we`.
- R8: A register-type word (opcode 0) with function 0x08 loads `pc` with `rs_val`.
- R9: For the R8 instruction, when `rs_val[1:0]` is non-zero, `misalign` is 1 in that cycle and `pc` still loads the unaligned value.
- R10: While `stall` is high, `pc` keeps its value, and `link_we` and `misalign` are 0.
- R11: A jump placed in the last word of a region takes its upper four bits from the next region. For example, a jump at 0x0FFFFFFC with field 0x10 lands at 0x10000040.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Freeze PC and suppress side effects |
| instr | input | XLEN | Instruction word for the current PC |
| rs_val | input | XLEN | First register operand (bits 25:21 selector) |
| rt_val | input | XLEN | Second register operand (bits 20:16 selector) |
| pc | output | XLEN | Current fetch address |
| link_we | output | 1 | Link-write valid pulse |
| link_addr | output | RAW | Link destination register, fixed at LINK_REG |
| link_data | output | XLEN | Return address pc+4 |
| misalign | output | 1 | Register-jump target not word aligned |

## Verification
The bench builds the unit with its default parameters: XLEN 32, RAW 5, LINK_REG 31 and RESET_PC 0x00400000. The reset address is far from any region boundary. To reach R11 and the backward branches, the bench first steers the PC with a register jump to each vector's start address, and then applies the instruction under test. With these defaults the link destination is 31 and the region field is the top four bits, so both are checked against their fixed values.

// File: rtl/pcn_pkg.sv
package pcn_pkg;
  typedef enum logic [1:0] {
    NXT_SEQ    = 2'd0,
    NXT_BRANCH = 2'd1,
    NXT_JUMP   = 2'd2,
    NXT_REG    = 2'd3
  } nxt_sel_e;

  localparam logic [5:0] OPC_SPECIAL = 6'd0;
  localparam logic [5:0] OPC_JMP     = 6'd2;
  localparam logic [5:0] OPC_JLINK   = 6'd3;
  localparam logic [5:0] OPC_BREQ    = 6'd4;
  localparam logic [5:0] OPC_BRNE    = 6'd5;
  localparam logic [5:0] FN_JREG     = 6'h08;
endpackage

// File: rtl/pcn_decode.sv
module pcn_decode #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output pcn_pkg::nxt_sel_e sel,
  output logic            is_link,
  output logic            is_jreg
);
  import pcn_pkg::*;

  logic [5:0] opc;
  logic [5:0] fn;
  logic       same;

  assign opc  = instr[31:26];
  assign fn   = instr[5:0];
  assign same = (rs_val == rt_val);

  always_comb begin
    sel     = NXT_SEQ;
    is_link = 1'b0;
    is_jreg = 1'b0;
    unique case (opc)
      OPC_BREQ:  if (same)  sel = NXT_BRANCH;
      OPC_BRNE:  if (!same) sel = NXT_BRANCH;
      OPC_JMP:   sel = NXT_JUMP;
      OPC_JLINK: begin
        sel     = NXT_JUMP;
        is_link = 1'b1;
      end
      OPC_SPECIAL: if (fn == FN_JREG) begin
        sel     = NXT_REG;
        is_jreg = 1'b1;
      end
      default: sel = NXT_SEQ;
    endcase
  end
endmodule

// File: rtl/pcn_targets.sv
module pcn_targets #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  pcn_pkg::nxt_sel_e sel,
  output logic [XLEN-1:0] seq_pc,
  output logic [XLEN-1:0] next_pc
);
  import pcn_pkg::*;

  localparam int OFS_W  = 16;
  localparam int TGT_W  = 26;
  localparam int REGION = XLEN - TGT_W - 2;

  logic [XLEN-1:0] br_ofs;
  logic [XLEN-1:0] br_pc;
  logic [XLEN-1:0] jmp_pc;

  assign seq_pc = pc + XLEN'(4);
  assign br_ofs = {{(XLEN-OFS_W-2){instr[OFS_W-1]}}, instr[OFS_W-1:0], 2'b00};
  assign br_pc  = seq_pc + br_ofs;
  assign jmp_pc = {seq_pc[XLEN-1 -: REGION], instr[TGT_W-1:0], 2'b00};

  always_comb begin
    unique case (sel)
      NXT_BRANCH: next_pc = br_pc;
      NXT_JUMP:   next_pc = jmp_pc;
      NXT_REG:    next_pc = rs_val;
      default:    next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pcn_reg.sv
module pcn_reg #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RESET_PC;
    else if (load) q <= d;
  end
endmodule

// File: rtl/pc_nextaddr.sv
module pc_nextaddr #(
  parameter int              XLEN     = 32,
  parameter int              RAW      = 5,
  parameter int              LINK_REG = 31,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            stall,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output logic [XLEN-1:0] pc,
  output logic            link_we,
  output logic [RAW-1:0]  link_addr,
  output logic [XLEN-1:0] link_data,
  output logic            misalign
);
  import pcn_pkg::*;

  nxt_sel_e        sel;
  logic            is_link;
  logic            is_jreg;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] next_pc;
  logic            advance;

  assign advance = !stall && !rst;

  pcn_decode #(.XLEN(XLEN)) u_dec (
    .instr   (instr),
    .rs_val  (rs_val),
    .rt_val  (rt_val),
    .sel     (sel),
    .is_link (is_link),
    .is_jreg (is_jreg)
  );

  pcn_targets #(.XLEN(XLEN)) u_tgt (
    .pc      (pc),
    .instr   (instr),
    .rs_val  (rs_val),
    .sel     (sel),
    .seq_pc  (seq_pc),
    .next_pc (next_pc)
  );

  pcn_reg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .load (!stall),
    .d    (next_pc),
    .q    (pc)
  );

  assign link_we   = advance && is_link;
  assign link_addr = RAW'(LINK_REG);
  assign link_data = seq_pc;
  assign misalign  = advance && is_jreg && (rs_val[1:0] != 2'b00);
endmodule

// File: rtl/pcn_checker.sv
module pcn_checker #(
  parameter int XLEN     = 32,
  parameter int RAW      = 5,
  parameter int LINK_REG = 31
) (
  input logic            clk,
  input logic            rst,
  input logic            stall,
  input logic [XLEN-1:0] instr,
  input logic [XLEN-1:0] rs_val,
  input logic [XLEN-1:0] rt_val,
  input logic [XLEN-1:0] pc,
  input logic            link_we,
  input logic [RAW-1:0]  link_addr,
  input logic [XLEN-1:0] link_data,
  input logic            misalign
);
  logic [5:0] op;
  logic       plain;
  assign op    = instr[31:26];
  assign plain = !(op inside {6'd2, 6'd3, 6'd4, 6'd5}) &&
                 !(op == 6'd0 && instr[5:0] == 6'h08);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc)); // R10

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && plain) |=> pc == $past(pc) + XLEN'(4)); // R2

  AST_BREQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!stall && op == 6'd4 && rs_val == rt_val) |=>
      pc == $past(pc) + XLEN'(4) + {{(XLEN-18){$past(instr[15])}}, $past(instr[15:0]), 2'b00}); // R3

  AST_JREG_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!stall && op == 6'd0 && instr[5:0] == 6'h08) |=> pc == $past(rs_val)); // R8

  AST_LINK_SRC: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (op == 6'd3 && !stall)); // R7

  AST_LINK_FIELDS: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_addr == RAW'(LINK_REG) && link_data == pc + XLEN'(4))); // R7

  AST_MISALIGN_SRC: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (rs_val[1:0] != 2'b00 && !stall)); // R9
endmodule

bind pc_nextaddr pcn_checker #(.XLEN(XLEN), .RAW(RAW), .LINK_REG(LINK_REG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall     (stall),
  .instr     (instr),
  .rs_val    (rs_val),
  .rt_val    (rt_val),
  .pc        (pc),
  .link_we   (link_we),
  .link_addr (link_addr),
  .link_data (link_data),
  .misalign  (misalign)
);

// File: tb/pc_nextaddr_tb.sv
module pc_nextaddr_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        stall;
  logic [31:0] instr;
  logic [31:0] rs_val;
  logic [31:0] rt_val;
  logic [31:0] pc;
  logic        link_we;
  logic [4:0]  link_addr;
  logic [31:0] link_data;
  logic        misalign;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pc_nextaddr u_dut (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .link_we(link_we),
    .link_addr(link_addr), .link_data(link_data), .misalign(misalign)
  );

  localparam logic [31:0] JREG_R1 = 32'h0020_0008;

  typedef struct packed {
    logic [7:0]  req;
    logic [31:0] start_pc;
    logic [31:0] ins;
    logic [31:0] rs;
    logic [31:0] rt;
    logic        stl;
    logic [31:0] exp_pc;
    logic        exp_link;
    logic        exp_mis;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{8'd3,  32'h0040_0010, 32'h1022_0004, 32'd5, 32'd5, 1'b0, 32'h0040_0024, 1'b0, 1'b0}, // R3 taken
    '{8'd3,  32'h0040_0010, 32'h1022_0004, 32'd5, 32'd6, 1'b0, 32'h0040_0014, 1'b0, 1'b0}, // R3 not taken
    '{8'd5,  32'h0040_0100, 32'h1422_FFFE, 32'd1, 32'd2, 1'b0, 32'h0040_00FC, 1'b0, 1'b0}, // R5 backward, R4 taken
    '{8'd4,  32'h0040_0100, 32'h1422_FFFE, 32'd7, 32'd7, 1'b0, 32'h0040_0104, 1'b0, 1'b0}, // R4 not taken
    '{8'd6,  32'h0040_0000, 32'h0812_3456, 32'd0, 32'd0, 1'b0, 32'h0048_D158, 1'b0, 1'b0}, // R6
    '{8'd7,  32'h0040_0020, 32'h0C10_0040, 32'd0, 32'd0, 1'b0, 32'h0040_0100, 1'b1, 1'b0}, // R7
    '{8'd9,  32'h0040_0040, 32'h0020_0008, 32'h0040_0102, 32'd0, 1'b0, 32'h0040_0102, 1'b0, 1'b1}, // R9
    '{8'd2,  32'h0040_0200, 32'h0022_1820, 32'd3, 32'd4, 1'b0, 32'h0040_0204, 1'b0, 1'b0}, // R2 register-type
    '{8'd11, 32'h0FFF_FFFC, 32'h0800_0010, 32'd0, 32'd0, 1'b0, 32'h1000_0040, 1'b0, 1'b0}, // R11
    '{8'd10, 32'h0040_0040, 32'h0C10_0040, 32'd0, 32'd0, 1'b1, 32'h0040_0040, 1'b0, 1'b0}, // R10
    '{8'd2,  32'h0040_0300, 32'h1800_0005, 32'd0, 32'd0, 1'b0, 32'h0040_0304, 1'b0, 1'b0}  // R2 other opcode
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_pc(input logic [31:0] v);
    @(negedge clk);
    stall = 1'b0; instr = JREG_R1; rs_val = v; rt_val = '0;
    @(posedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    set_pc(v.start_pc);
    @(negedge clk);
    stall = v.stl; instr = v.ins; rs_val = v.rs; rt_val = v.rt;
    #1;
    check({tag, " link_we"}, {31'd0, link_we}, {31'd0, v.exp_link});
    check({tag, " misalign"}, {31'd0, misalign}, {31'd0, v.exp_mis});
    if (v.exp_link) begin
      check({tag, " link_addr"}, {27'd0, link_addr}, 32'd31);
      check({tag, " link_data"}, link_data, v.start_pc + 32'd4);
    end
    @(posedge clk); #1;
    check({tag, " pc"}, pc, v.exp_pc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; stall = 1'b0; instr = 32'h0C10_0040; rs_val = '0; rt_val = '0;
    @(posedge clk); #1;
    check("R1 link_we in reset", {31'd0, link_we}, 32'd0);
    @(posedge clk); #1;
    check("R1 reset pc", pc, 32'h0040_0000);
    @(negedge clk);
    rst = 1'b0; instr = 32'h0022_1820;
    @(posedge clk); #1;
    check("R2 first step", pc, 32'h0040_0004);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: hold across several cycles with a misaligned register jump present
    set_pc(32'h0040_0500);
    @(negedge clk);
    stall = 1'b1; instr = JREG_R1; rs_val = 32'h0000_0003;
    #1;
    check("R10 misalign while stalled", {31'd0, misalign}, 32'd0);
    repeat (3) @(posedge clk);
    #1;
    check("R10 pc held", pc, 32'h0040_0500);

    // R1: reset mid-run overrides a pending jump
    @(negedge clk);
    stall = 1'b0; rst = 1'b1; instr = 32'h0812_3456;
    @(posedge clk); #1;
    check("R1 reset mid-run", pc, 32'h0040_0000);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule